// File: doc/BRIEF.md
# Boot-Block Write Protection Gate

This block sits between a Flash command decoder and its program/erase engine. For every program or erase request it decides, one clock later, whether the addressed block may be altered. Three inputs feed that decision: a per-block software protection bit, a write-protect pin that locks the two lowest and the two highest blocks of the array, and a reset pin whose elevated level lifts software protection for as long as it is held. The gate also reports which of the four banks the block sits in. The banks split the array in the ratio 1:3:3:1, and parameter blocks sit at both ends.

The same write-protect pin has a third, elevated level. Raising the pin to that level while the controller is idle in read mode turns on an unlock-bypass mode. Raising it from any other controller mode is refused and flagged. The reset pin also acts as a hardware reset, but only when held low for a minimum number of clocks. After release, bus operations stay blocked for a recovery window. A ready/busy output goes low while the controller programs or erases, and it also stays low through reset and recovery.

Top module: `bootblk_guard`

## Requirements
- R1: Pin levels are encoded on two bits: 2'b00 low, 2'b01 high, 2'b10 elevated. Code 2'b11 is treated as high.
- R2: With the write-protect pin low, requests to blocks 0, 1, NUM_BLOCKS-2 and NUM_BLOCKS-1 are refused whatever their protection bits. This holds even while the reset pin is elevated.
- R3: With the write-protect pin high or elevated and the reset pin high, every block, boot blocks included, is refused exactly when its bit in prot_bits is 1.
- R4: While the reset pin is elevated, every block is allowed except the four boot blocks when the write-protect pin is low.
- R5: A request presented with req_valid gives dec_valid=1 one clock later. In that same cycle dec_allow carries the decision and dec_erase echoes req_erase. dec_valid is 0 in all other cycles.
- R6: When the write-protect pin changes to elevated while ctl_state is 0 (read), bypass_on is 1 from the next clock. It returns to 0 on the clock after the pin leaves the elevated level.
- R7: When the write-protect pin changes to elevated while ctl_state is not 0, bypass_err is 1 for exactly one clock and bypass_on stays 0. It stays 0 until the pin leaves the elevated level and is raised again.
- R8: With bus_ready=1, ready is 0 when ctl_state is 2 (program) or 3 (erase). It is 1 when ctl_state is 0 (read), 1 (auto-select) or 4 (erase suspend).
- R9: Sampling the reset pin low on RST_MIN_CYC consecutive clocks starts a hardware reset. From that clock, bus_ready and ready are 0 and bypass_on is cleared. A shorter low pulse has no effect on any output.
- R10: When the reset pin leaves the low level after a hardware reset, bus_ready returns to 1 on the (RECOVER_CYC+1)-th clock after the release. A request presented while bus_ready is 0 is refused.
- R11: dec_bank is 0 for blocks below NUM_BLOCKS/8, 1 below NUM_BLOCKS/2, 2 below 7*NUM_BLOCKS/8, and 3 above that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the logic |
| wp_lvl | input | 2 | Encoded write-protect / programming-voltage pin level |
| rp_lvl | input | 2 | Encoded reset / temporary-unprotect pin level |
| ctl_state | input | 3 | Controller mode: 0 read, 1 auto-select, 2 program, 3 erase, 4 erase suspend |
| req_valid | input | 1 | Program or erase request strobe |
| req_erase | input | 1 | 1 = erase request, 0 = program request |
| req_blk | input | $clog2(NUM_BLOCKS) | Target block index |
| prot_bits | input | NUM_BLOCKS | Stored protection bit per block, 1 = protected |
| dec_valid | output | 1 | Decision strobe, one clock after the request |
| dec_allow | output | 1 | 1 = request may proceed, 0 = ignore it |
| dec_erase | output | 1 | Request type belonging to the decision |
| dec_bank | output | 2 | Bank holding the requested block |
| bypass_on | output | 1 | Unlock-bypass mode active |
| bypass_err | output | 1 | One-clock flag for a refused bypass entry |
| ready | output | 1 | Ready/busy: 0 while busy or in reset/recovery |
| bus_ready | output | 1 | 1 when bus operations may be accepted |

## Verification
The assertions assume the pin-level inputs and ctl_state change only between clock edges and hold steady for a whole cycle. They also assume the controller mode only takes the five listed codes. The bench drives every input on the falling edge and keeps ctl_state within those five codes. The reset pin is driven low only in the tasks that test reset pulses, so protection results are never taken while a reset is in progress.

// File: rtl/bbg_pkg.sv
package bbg_pkg;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'b00,
    LVL_HIGH = 2'b01,
    LVL_ELEV = 2'b10,
    LVL_RSVD = 2'b11
  } lvl_e;

  typedef enum logic [2:0] {
    CS_READ    = 3'd0,
    CS_AUTOSEL = 3'd1,
    CS_PROG    = 3'd2,
    CS_ERASE   = 3'd3,
    CS_ESUSP   = 3'd4
  } ctl_e;

  // R1: reserved code counts as high, so only 2'b10 is elevated
  function automatic logic lvl_is_low(input logic [1:0] lvl);
    return lvl == LVL_LOW;
  endfunction

  function automatic logic lvl_is_elev(input logic [1:0] lvl);
    return lvl == LVL_ELEV;
  endfunction

  // outermost two blocks on each side of the array
  function automatic logic blk_is_boot(input int unsigned blk, input int unsigned nblk);
    return (blk < 2) || (blk + 2 >= nblk);
  endfunction

  // bank split 1:3:3:1 of the block count
  function automatic logic [1:0] blk_bank(input int unsigned blk, input int unsigned nblk);
    if (blk * 8 < nblk)          return 2'd0;
    else if (blk * 8 < nblk * 4) return 2'd1;
    else if (blk * 8 < nblk * 7) return 2'd2;
    else                         return 2'd3;
  endfunction

  function automatic logic ctl_is_busy(input logic [2:0] st);
    return (st == CS_PROG) || (st == CS_ERASE);
  endfunction

endpackage

// File: rtl/bbg_reset_seq.sv
module bbg_reset_seq
  import bbg_pkg::*;
#(
  parameter int RST_MIN_CYC = 4,
  parameter int RECOVER_CYC = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rp_lvl,
  output logic       in_reset,
  output logic       bus_ready
);

  localparam int CW = $clog2(RST_MIN_CYC + 1);
  localparam int RW = $clog2(RECOVER_CYC + 1);

  logic [CW-1:0] low_cnt;
  logic [RW-1:0] rec_cnt;
  logic          rp_low;
  logic          long_enough;

  assign rp_low      = lvl_is_low(rp_lvl);
  assign long_enough = low_cnt >= CW'(RST_MIN_CYC - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      in_reset <= 1'b0;
      rec_cnt  <= '0;
    end else if (rp_low) begin
      if (low_cnt != CW'(RST_MIN_CYC)) low_cnt <= low_cnt + 1'b1;
      if (long_enough) in_reset <= 1'b1;
    end else begin
      low_cnt <= '0;
      if (in_reset) begin
        in_reset <= 1'b0;
        rec_cnt  <= RW'(RECOVER_CYC);
      end else if (rec_cnt != '0) begin
        rec_cnt <= rec_cnt - 1'b1;
      end
    end
  end

  assign bus_ready = !in_reset && (rec_cnt == '0);

  // R9: reset only begins after the pin was sampled low
  assert_reset_needs_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_reset) |-> $past(rp_lvl) == LVL_LOW);

  // R10: leaving reset always enters the recovery window first
  assert_recovery_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_reset) |-> !bus_ready);

endmodule

// File: rtl/bbg_bypass_ctl.sv
module bbg_bypass_ctl
  import bbg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] wp_lvl,
  input  logic [2:0] ctl_state,
  input  logic       in_reset,
  output logic       bypass_on,
  output logic       bypass_err
);

  logic wp_elev;
  logic wp_elev_q;
  logic enter_req;
  logic from_read;

  assign wp_elev   = lvl_is_elev(wp_lvl);
  assign enter_req = wp_elev && !wp_elev_q;
  assign from_read = ctl_state == CS_READ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_elev_q  <= 1'b0;
      bypass_on  <= 1'b0;
      bypass_err <= 1'b0;
    end else begin
      wp_elev_q <= wp_elev;
      if (in_reset) begin
        bypass_on  <= 1'b0;
        bypass_err <= 1'b0;
      end else begin
        bypass_err <= enter_req && !from_read;
        if (!wp_elev)                    bypass_on <= 1'b0;
        else if (enter_req && from_read) bypass_on <= 1'b1;
      end
    end
  end

  // R6: entry happens only out of read mode
  assert_bypass_from_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bypass_on) |-> $past(ctl_state) == CS_READ);

  // R6: bypass is only held while the pin was elevated
  assert_bypass_needs_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_on |-> $past(wp_lvl) == LVL_ELEV);

  // R7: a refused entry never coexists with bypass
  assert_err_excludes_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bypass_err |-> !bypass_on);

endmodule

// File: rtl/bbg_prot_eval.sv
module bbg_prot_eval
  import bbg_pkg::*;
#(
  parameter int NUM_BLOCKS = 16,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic                  req_erase,
  input  logic [BLK_W-1:0]      req_blk,
  input  logic [NUM_BLOCKS-1:0] prot_bits,
  input  logic [1:0]            wp_lvl,
  input  logic [1:0]            rp_lvl,
  input  logic                  bus_ready,
  output logic                  dec_valid,
  output logic                  dec_allow,
  output logic                  dec_erase,
  output logic [1:0]            dec_bank
);

  logic [NUM_BLOCKS-1:0] lock_vec;
  logic                  wp_low;
  logic                  rp_elev;
  logic                  blk_locked;
  logic                  req_boot;

  assign wp_low  = lvl_is_low(wp_lvl);
  assign rp_elev = lvl_is_elev(rp_lvl);

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_lock
    localparam logic BOOT = blk_is_boot(i, NUM_BLOCKS);
    if (BOOT) begin : g_boot
      assign lock_vec[i] = wp_low || (!rp_elev && prot_bits[i]);
    end else begin : g_main
      assign lock_vec[i] = !rp_elev && prot_bits[i];
    end
  end

  assign blk_locked = lock_vec[req_blk];
  assign req_boot   = blk_is_boot(32'(req_blk), NUM_BLOCKS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      dec_allow <= 1'b0;
      dec_erase <= 1'b0;
      dec_bank  <= 2'd0;
    end else begin
      dec_valid <= req_valid;
      dec_allow <= req_valid && bus_ready && !blk_locked;
      if (req_valid) begin
        dec_erase <= req_erase;
        dec_bank  <= blk_bank(32'(req_blk), NUM_BLOCKS);
      end
    end
  end

  // R2: hardware lock of boot blocks wins over everything
  assert_boot_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && wp_low && req_boot |=> dec_valid && !dec_allow);

  // R4: elevated reset pin opens non-boot blocks
  assert_temp_unprot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && bus_ready && rp_elev && !req_boot |=> dec_allow);

  // R10: nothing is granted while the bus is not ready
  assert_no_grant_unready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !bus_ready |=> !dec_allow);

  // R5: decision strobe tracks the request one clock later
  assert_strobe_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(req_valid));

endmodule

// File: rtl/bootblk_guard.sv
module bootblk_guard
  import bbg_pkg::*;
#(
  parameter int NUM_BLOCKS  = 16,
  parameter int RST_MIN_CYC = 4,
  parameter int RECOVER_CYC = 6,
  localparam int BLK_W = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            wp_lvl,
  input  logic [1:0]            rp_lvl,
  input  logic [2:0]            ctl_state,
  input  logic                  req_valid,
  input  logic                  req_erase,
  input  logic [BLK_W-1:0]      req_blk,
  input  logic [NUM_BLOCKS-1:0] prot_bits,
  output logic                  dec_valid,
  output logic                  dec_allow,
  output logic                  dec_erase,
  output logic [1:0]            dec_bank,
  output logic                  bypass_on,
  output logic                  bypass_err,
  output logic                  ready,
  output logic                  bus_ready
);

  logic in_reset;

  bbg_reset_seq #(
    .RST_MIN_CYC(RST_MIN_CYC),
    .RECOVER_CYC(RECOVER_CYC)
  ) u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rp_lvl   (rp_lvl),
    .in_reset (in_reset),
    .bus_ready(bus_ready)
  );

  bbg_bypass_ctl u_byp (
    .clk       (clk),
    .rst_n     (rst_n),
    .wp_lvl    (wp_lvl),
    .ctl_state (ctl_state),
    .in_reset  (in_reset),
    .bypass_on (bypass_on),
    .bypass_err(bypass_err)
  );

  bbg_prot_eval #(
    .NUM_BLOCKS(NUM_BLOCKS)
  ) u_prot (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_erase(req_erase),
    .req_blk  (req_blk),
    .prot_bits(prot_bits),
    .wp_lvl   (wp_lvl),
    .rp_lvl   (rp_lvl),
    .bus_ready(bus_ready),
    .dec_valid(dec_valid),
    .dec_allow(dec_allow),
    .dec_erase(dec_erase),
    .dec_bank (dec_bank)
  );

  assign ready = bus_ready && !ctl_is_busy(ctl_state);

  // R9: a hardware reset in progress clears bypass by the next clock
  assert_reset_clears_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_reset |=> !bypass_on);

endmodule

// File: tb/bootblk_guard_test.sv
`timescale 1ns/1ps
module bootblk_guard_test;

  localparam int N    = 16;
  localparam int RMIN = 4;
  localparam int RREC = 6;
  localparam int BW   = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    wp_lvl, rp_lvl;
  logic [2:0]    ctl_state;
  logic          req_valid, req_erase;
  logic [BW-1:0] req_blk;
  logic [N-1:0]  prot_bits;
  logic          dec_valid, dec_allow, dec_erase, bypass_on, bypass_err, ready, bus_ready;
  logic [1:0]    dec_bank;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  bootblk_guard #(.NUM_BLOCKS(N), .RST_MIN_CYC(RMIN), .RECOVER_CYC(RREC)) uut (
    .clk(clk), .rst_n(rst_n), .wp_lvl(wp_lvl), .rp_lvl(rp_lvl), .ctl_state(ctl_state),
    .req_valid(req_valid), .req_erase(req_erase), .req_blk(req_blk), .prot_bits(prot_bits),
    .dec_valid(dec_valid), .dec_allow(dec_allow), .dec_erase(dec_erase), .dec_bank(dec_bank),
    .bypass_on(bypass_on), .bypass_err(bypass_err), .ready(ready), .bus_ready(bus_ready)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // independent reference for the grant decision
  function automatic int ref_allow(int blk, logic [1:0] wp, logic [1:0] rp, logic [N-1:0] bits);
    bit edge_blk = (blk == 0) || (blk == 1) || (blk == N - 1) || (blk == N - 2);
    if (wp == 2'b00 && edge_blk) return 0;
    if (rp == 2'b10) return 1;
    return bits[blk] ? 0 : 1;
  endfunction

  function automatic int ref_bank(int blk);
    if (blk < N / 8) return 0;
    if (blk < N / 2) return 1;
    if (blk < N - N / 8) return 2;
    return 3;
  endfunction

  task automatic send(input int blk, input logic ers, input string tag, input int exp_allow);
    req_valid = 1'b1;
    req_erase = ers;
    req_blk   = BW'(blk);
    step();
    req_valid = 1'b0;
    check({tag, " R5 strobe"}, int'(dec_valid), 1);
    check({tag, " allow"}, int'(dec_allow), exp_allow);
    check({tag, " R5 kind"}, int'(dec_erase), int'(ers));
    step();
    check({tag, " R5 strobe drop"}, int'(dec_valid), 0);
  endtask

  task automatic sweep(input string tag);
    for (int b = 0; b < N; b++)
      send(b, b[0], tag, ref_allow(b, wp_lvl, rp_lvl, prot_bits));
  endtask

  task automatic t_reset_state();
    check("R5 reset dec_valid", int'(dec_valid), 0);
    check("R6 reset bypass", int'(bypass_on), 0);
    check("R10 reset bus_ready", int'(bus_ready), 1);
    check("R8 reset ready", int'(ready), 1);
  endtask

  task automatic t_boot_lock();
    prot_bits = '0;
    wp_lvl = 2'b00; rp_lvl = 2'b01;
    sweep("R2 wp low rp high");
    rp_lvl = 2'b10;
    sweep("R2 wp low rp elevated");
    prot_bits = '1;
    sweep("R2 R4 wp low rp elevated all bits");
  endtask

  task automatic t_stored_bits();
    rp_lvl = 2'b01;
    prot_bits = 16'hA5C3;
    wp_lvl = 2'b01;
    sweep("R3 wp high");
    wp_lvl = 2'b11;
    sweep("R1 R3 wp reserved code");
    prot_bits = 16'h5A3C;
    wp_lvl = 2'b01;
    sweep("R3 wp high pattern2");
  endtask

  task automatic t_temp_unprot();
    prot_bits = '1;
    wp_lvl = 2'b01; rp_lvl = 2'b10;
    sweep("R4 rp elevated");
    rp_lvl = 2'b01;
  endtask

  task automatic t_bank_map();
    prot_bits = '0; wp_lvl = 2'b01;
    for (int b = 0; b < N; b++) begin
      req_valid = 1'b1; req_erase = 1'b0; req_blk = BW'(b);
      step();
      req_valid = 1'b0;
      check($sformatf("R11 bank blk %0d", b), int'(dec_bank), ref_bank(b));
    end
    step();
  endtask

  task automatic t_bypass();
    ctl_state = 3'd0; wp_lvl = 2'b01;
    step();
    wp_lvl = 2'b10;
    step();
    check("R6 bypass entered", int'(bypass_on), 1);
    check("R6 no error", int'(bypass_err), 0);
    step();
    check("R6 bypass held", int'(bypass_on), 1);
    wp_lvl = 2'b00;
    step();
    check("R6 bypass left", int'(bypass_on), 0);
    wp_lvl = 2'b01;
    step();
  endtask

  task automatic t_bypass_err();
    ctl_state = 3'd2;
    wp_lvl = 2'b10;
    step();
    check("R7 error flag", int'(bypass_err), 1);
    check("R7 no bypass", int'(bypass_on), 0);
    ctl_state = 3'd0;
    step();
    check("R7 error one cycle", int'(bypass_err), 0);
    check("R7 still no bypass", int'(bypass_on), 0);
    wp_lvl = 2'b01;
    step();
    wp_lvl = 2'b10;
    step();
    check("R7 re-raise enters", int'(bypass_on), 1);
    wp_lvl = 2'b01;
    step();
  endtask

  task automatic t_busy();
    for (int s = 0; s < 5; s++) begin
      ctl_state = 3'(s);
      #1;
      check($sformatf("R8 ready state %0d", s), int'(ready), (s == 2 || s == 3) ? 0 : 1);
    end
    ctl_state = 3'd0;
    step();
  endtask

  task automatic t_short_pulse();
    rp_lvl = 2'b00;
    for (int i = 0; i < RMIN - 1; i++) begin
      step();
      check("R9 short pulse bus_ready", int'(bus_ready), 1);
    end
    rp_lvl = 2'b01;
    step();
    check("R9 short pulse after", int'(bus_ready), 1);
    check("R9 short pulse ready", int'(ready), 1);
  endtask

  task automatic t_hw_reset();
    ctl_state = 3'd0; wp_lvl = 2'b10;
    step();
    check("R6 bypass before reset", int'(bypass_on), 1);
    rp_lvl = 2'b00;
    for (int i = 1; i <= RMIN + 1; i++) begin
      step();
      check($sformatf("R9 bus_ready low cycle %0d", i), int'(bus_ready), (i >= RMIN) ? 0 : 1);
    end
    check("R9 ready low in reset", int'(ready), 0);
    step();
    check("R9 bypass cleared", int'(bypass_on), 0);
    rp_lvl = 2'b01; wp_lvl = 2'b01; prot_bits = '0;
    for (int i = 1; i <= RREC; i++) begin
      step();
      check($sformatf("R10 recovery cycle %0d", i), int'(bus_ready), 0);
    end
    req_valid = 1'b1; req_erase = 1'b1; req_blk = BW'(5);
    step();
    req_valid = 1'b0;
    check("R10 request during recovery refused", int'(dec_allow), 0);
    check("R10 bus_ready back", int'(bus_ready), 1);
    check("R10 ready back", int'(ready), 1);
    step();
    send(5, 1'b1, "R10 request after recovery", 1);
  endtask

  initial begin
    #(8.0 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wp_lvl = 2'b01; rp_lvl = 2'b01; ctl_state = 3'd0;
    req_valid = 1'b0; req_erase = 1'b0; req_blk = '0; prot_bits = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset_state();
    t_boot_lock();
    t_stored_bits();
    t_temp_unprot();
    t_bank_map();
    t_bypass();
    t_bypass_err();
    t_busy();
    t_short_pulse();
    t_hw_reset();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule